// File: doc/BRIEF.md
# Bidirectional Universal Shift Register

This block is a parameterised register of `WIDTH` bits whose next content is chosen on every rising clock edge by a two-bit mode input. There are four operating states. HOLD keeps the word. SHIFT_UP moves every bit one place toward the high index and takes a new bit in at index 0. SHIFT_DOWN moves every bit one place toward the low index and takes a new bit in at the top index. LOAD copies a parallel word into the register.

Each shift direction has its own serial input. Two or more instances can therefore be cascaded into a wider shifter that works in both directions with plain wires and no external multiplexers.

An active-low clear empties the register at once, without waiting for a clock edge, and holds it empty while it is asserted. The only transitions are these:
- clear to whichever state the mode selects at the first edge after release;
- any state to any other state on the next edge, as the mode input changes;
- any state to clear as soon as the clear input goes low.

Top module: `usr_shift_reg`

## Requirements
- R1: While `rst_n` is 0, `q` is all zeros immediately, without a clock edge, whatever the mode, serial and parallel inputs are.
- R2: With `mode` = 2'b00 (HOLD), a rising edge leaves `q` unchanged.
- R3: With `mode` = 2'b01 (SHIFT_UP), a rising edge sets `q[0]` to `in_up` and each `q[i]` for i ≥ 1 to the old `q[i-1]`.
- R4: With `mode` = 2'b10 (SHIFT_DOWN), a rising edge sets `q[WIDTH-1]` to `in_down` and each `q[i]` for i < WIDTH-1 to the old `q[i+1]`.
- R5: With `mode` = 2'b11 (LOAD), a rising edge sets `q[i]` to `load_d[i]` for every i.
- R6: Mode and data inputs act only at a rising edge; changing them between edges leaves `q` unchanged.
- R7: `in_up` and `in_down` have no effect in HOLD or LOAD, and `load_d` has no effect in HOLD, SHIFT_UP or SHIFT_DOWN.
- R8: The first rising edge after `rst_n` returns to 1 performs the selected operation, with no extra cycle of latency.
- R9: Two instances wired with the lower `q[WIDTH-1]` driving the upper `in_up`, and the upper `q[0]` driving the lower `in_down`, behave as one register of width 2·WIDTH in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all operations occur on its rising edge |
| rst_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | 00 HOLD, 01 SHIFT_UP, 10 SHIFT_DOWN, 11 LOAD |
| in_up | input | 1 | Serial bit that enters index 0 in SHIFT_UP |
| in_down | input | 1 | Serial bit that enters index WIDTH-1 in SHIFT_DOWN |
| load_d | input | WIDTH | Parallel word for LOAD |
| q | output | WIDTH | Register contents |

## Verification
The clocked properties assume that `mode`, `in_up`, `in_down` and `load_d` are settled before each rising edge. They also assume that `rst_n` never changes at a rising edge, so the value sampled at an edge is the one that acted on the register. The bench changes every input, including the clear, only on falling clock edges. The one exception is the mid-cycle test for R6, which alters inputs shortly after a rising edge and restores them before the next one. Under these conditions each property compares the register with the value that its mode and inputs at the previous edge call for.

// File: rtl/usr_pkg.sv
package usr_pkg;

    typedef enum logic [1:0] {
        ST_HOLD       = 2'b00,
        ST_SHIFT_UP   = 2'b01,
        ST_SHIFT_DOWN = 2'b10,
        ST_LOAD       = 2'b11
    } usr_mode_e;

endpackage

// File: rtl/usr_mode_decode.sv
module usr_mode_decode
    import usr_pkg::*;
(
    input  logic [1:0] mode_bits,
    output usr_mode_e  mode_sel
);

    // Two-bit code maps directly onto the four operating states.
    always_comb begin
        mode_sel = usr_mode_e'(mode_bits);
    end

endmodule

// File: rtl/usr_stage.sv
module usr_stage
    import usr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  usr_mode_e mode_sel,
    input  logic      from_lo,
    input  logic      from_hi,
    input  logic      load_bit,
    output logic      bit_q
);

    logic bit_nxt;

    always_comb begin
        bit_nxt = bit_q;
        unique case (mode_sel)
            ST_HOLD:       bit_nxt = bit_q;
            ST_SHIFT_UP:   bit_nxt = from_lo;
            ST_SHIFT_DOWN: bit_nxt = from_hi;
            ST_LOAD:       bit_nxt = load_bit;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
        end else begin
            bit_q <= bit_nxt;
        end
    end

endmodule

// File: rtl/usr_shift_reg.sv
module usr_shift_reg
    import usr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             in_up,
    input  logic             in_down,
    input  logic [WIDTH-1:0] load_d,
    output logic [WIDTH-1:0] q
);

    localparam int TOP = WIDTH - 1;

    usr_mode_e        mode_sel;
    logic [TOP:0]     q_r;
    logic [TOP:0]     lo_nb;   // value each stage takes when shifting up
    logic [TOP:0]     hi_nb;   // value each stage takes when shifting down

    usr_mode_decode u_dec (
        .mode_bits (mode),
        .mode_sel  (mode_sel)
    );

    assign lo_nb = {q_r[TOP-1:0], in_up};
    assign hi_nb = {in_down, q_r[TOP:1]};

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        usr_stage u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode_sel (mode_sel),
            .from_lo  (lo_nb[i]),
            .from_hi  (hi_nb[i]),
            .load_bit (load_d[i]),
            .bit_q    (q_r[i])
        );
    end

    assign q = q_r;

    // R1: clear holds the register empty at every edge it covers
    a_r1_clear_empties: assert property (@(posedge clk)
        !rst_n |-> (q == '0));

    // R2: hold keeps the word
    a_r2_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> (q == $past(q)));

    // R3: shift toward high index
    a_r3_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |=> (q == {$past(q[TOP-1:0]), $past(in_up)}));

    // R4: shift toward low index
    a_r4_shift_down: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |=> (q == {$past(in_down), $past(q[TOP:1])}));

    // R5: parallel load, positions matched
    a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |=> (q == $past(load_d)));

endmodule

// File: tb/tb_usr_shift_reg.sv
module tb_usr_shift_reg;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       in_up = 1'b0, in_down = 1'b0;
    logic [3:0] load_d = '0;
    logic [3:0] q;

    logic       c_up = 1'b0, c_down = 1'b0;
    logic [7:0] c_load = '0;
    logic [3:0] lo_q, hi_q;
    logic [7:0] cq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [3:0] exp4 = '0;
    logic [7:0] exp8 = '0;

    typedef struct {
        logic [3:0] q;
        logic [7:0] cq;
        string      tag;
    } item_t;
    item_t sbq[$];

    always #5 clk = ~clk;

    usr_shift_reg #(.WIDTH(4)) dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .in_up(in_up),
        .in_down(in_down), .load_d(load_d), .q(q));

    // chained pair forming an 8-bit shifter (R9)
    usr_shift_reg #(.WIDTH(4)) u_lo (
        .clk(clk), .rst_n(rst_n), .mode(mode), .in_up(c_up),
        .in_down(hi_q[0]), .load_d(c_load[3:0]), .q(lo_q));
    usr_shift_reg #(.WIDTH(4)) u_hi (
        .clk(clk), .rst_n(rst_n), .mode(mode), .in_up(lo_q[3]),
        .in_down(c_down), .load_d(c_load[7:4]), .q(hi_q));

    assign cq = {hi_q, lo_q};

    function automatic logic [3:0] nxt4(logic [1:0] m, logic [3:0] c,
                                        logic u, logic d, logic [3:0] p);
        case (m)
            2'b00:   return c;
            2'b01:   return {c[2:0], u};
            2'b10:   return {d, c[3:1]};
            default: return p;
        endcase
    endfunction

    function automatic logic [7:0] nxt8(logic [1:0] m, logic [7:0] c,
                                        logic u, logic d, logic [7:0] p);
        case (m)
            2'b00:   return c;
            2'b01:   return {c[6:0], u};
            2'b10:   return {d, c[7:1]};
            default: return p;
        endcase
    endfunction

    function automatic string mode_tag(logic [1:0] m);
        case (m)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // driver: sets inputs on a falling edge, pushes the expected result
    task automatic apply(input logic rst, input logic [1:0] m,
                         input logic u, input logic d, input logic [3:0] p,
                         input logic cu, input logic cd, input logic [7:0] cp,
                         input string tag);
        item_t it;
        @(negedge clk);
        rst_n = rst; mode = m; in_up = u; in_down = d; load_d = p;
        c_up = cu; c_down = cd; c_load = cp;
        if (!rst) begin
            exp4 = '0; exp8 = '0;
            #1;
            chk(q == 4'h0, "R1 async clear", {4'h0, q}, 8'h00);
            chk(cq == 8'h00, "R1 async clear chain", cq, 8'h00);
        end else begin
            exp4 = nxt4(m, exp4, u, d, p);
            exp8 = nxt8(m, exp8, cu, cd, cp);
        end
        it.q = exp4; it.cq = exp8; it.tag = tag;
        sbq.push_back(it);
    endtask

    // monitor: compares shortly after each rising edge
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #2;
            if (sbq.size() > 0) begin
                it = sbq.pop_front();
                chk(q == it.q, it.tag, {4'h0, q}, {4'h0, it.q});
                chk(cq == it.cq, {"R9 chain ", it.tag}, cq, it.cq);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // reset state, R1
        #1;
        chk(q == 4'h0, "R1 reset state", {4'h0, q}, 8'h00);
        apply(0, 2'b11, 1, 1, 4'hF, 1, 1, 8'hFF, "R1");
        apply(0, 2'b01, 1, 1, 4'hF, 1, 1, 8'hFF, "R1");
        // R8: first edge after release loads
        apply(1, 2'b11, 0, 0, 4'hA, 0, 0, 8'h5C, "R8");
        // R2/R7: hold ignores serial and parallel inputs
        apply(1, 2'b00, 1, 1, 4'h5, 1, 1, 8'hA3, "R2 R7 hold");
        apply(1, 2'b00, 0, 1, 4'h0, 0, 1, 8'h00, "R2 R7 hold");
        // R3: shift up, patterns 1,0,1,1,0
        apply(1, 2'b01, 1, 0, 4'h3, 1, 0, 8'h11, "R3 R7");
        apply(1, 2'b01, 0, 1, 4'hC, 0, 1, 8'hEE, "R3 R7");
        apply(1, 2'b01, 1, 1, 4'h0, 1, 1, 8'h00, "R3");
        apply(1, 2'b01, 1, 0, 4'hF, 1, 0, 8'hFF, "R3");
        apply(1, 2'b01, 0, 0, 4'h9, 0, 0, 8'h42, "R3");
        // R4: shift down
        apply(1, 2'b10, 0, 1, 4'h6, 0, 1, 8'h77, "R4 R7");
        apply(1, 2'b10, 1, 0, 4'h1, 1, 0, 8'h18, "R4 R7");
        apply(1, 2'b10, 0, 1, 4'hF, 0, 1, 8'hFF, "R4");
        apply(1, 2'b10, 0, 0, 4'h0, 0, 0, 8'h00, "R4");
        // R5/R7: load ignores serial inputs
        apply(1, 2'b11, 1, 1, 4'h6, 1, 1, 8'h96, "R5 R7");
        apply(1, 2'b11, 0, 0, 4'h9, 0, 0, 8'h69, "R5 R7");
        // R6: inputs changed between edges have no effect
        @(posedge clk); #3;
        mode = 2'b11; load_d = ~exp4; in_up = 1; in_down = 1;
        c_load = ~exp8;
        #1;
        chk(q == exp4, "R6 mid-cycle", {4'h0, q}, {4'h0, exp4});
        chk(cq == exp8, "R6 mid-cycle chain", cq, exp8);
        // reset in the middle of a shift run (R1), then R8 with a shift
        apply(1, 2'b01, 1, 0, 4'h0, 1, 0, 8'h00, "R3");
        apply(1, 2'b01, 1, 0, 4'h0, 1, 0, 8'h00, "R3");
        apply(0, 2'b01, 1, 0, 4'h0, 1, 0, 8'h00, "R1 mid-shift");
        apply(1, 2'b01, 1, 1, 4'h0, 1, 1, 8'h00, "R8 shift");
        apply(1, 2'b10, 0, 1, 4'h0, 0, 1, 8'h00, "R8 R4");
        // mixed stimulus against the reference model
        for (int k = 0; k < 200; k++) begin
            logic [1:0] m;
            logic [31:0] r;
            r = $urandom;
            m = r[1:0];
            apply(1, m, r[2], r[3], r[7:4], r[8], r[9], r[17:10], mode_tag(m));
        end
        apply(1, 2'b00, 0, 0, 4'h0, 0, 0, 8'h00, "R2");
        @(posedge clk); #4;
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule